// File: doc/BRIEF.md
# Loss-of-Clock Watchdog Monitor

This block watches eight pairs of monitored clocks from a free-running reference clock. Each pair has a line receive clock and a PLL reference clock. Each monitored clock goes through a synchroniser into the reference domain, where an edge detector compares successive samples. A per-channel timeout counter restarts on every detected transition. When the counter runs a full timeout window without seeing an edge, that channel's alarm goes high.

The two kinds of channel recover differently. A line channel drops its alarm as soon as it detects the first edge. A PLL channel first enters a qualification window. It drops its alarm only when that window completes and the clock has not stalled in the meantime. A shared select input chooses which channel drives each of the two alarm outputs. All windows are parameters counted in reference cycles. The defaults give 250 ms and 250 µs at a 250 MHz reference, and a bench can pass short values instead.

Top module: `clk_loss_mon`

## Requirements
- R1: A channel's alarm rises exactly TIMEOUT_CYC reference cycles after the last detected edge. Counting from a monitored-clock toggle made between two reference rising edges, the alarm is high after the (TIMEOUT_CYC+3)-th rising edge and low just before it.
- R2: A line channel that is in alarm clears its alarm on the third reference rising edge after the first toggle of its clock.
- R3: A PLL channel that is in alarm clears its alarm QUAL_CYC reference cycles later than a line channel would. This requires its clock to keep toggling with gaps shorter than STALL_CYC cycles. Until then the alarm stays high.
- R4: Every detected transition, rising or falling, restarts the timeout count. A clock that toggles at intervals shorter than TIMEOUT_CYC never raises an alarm.
- R5: If no edge arrives for STALL_CYC cycles during qualification, the PLL channel's qualification is abandoned and its alarm stays high. The next edge starts a fresh, full qualification window.
- R6: The select value is a binary channel index (0 to 7). `line_alarm` shows the line alarm of channel `sel`, and `pll_alarm` shows the PLL alarm of channel `sel`. The mux is combinational.
- R7: While reset is applied, and for the two cycles of the synchronous reset release, both alarms are low and every counter holds zero. With all monitored clocks idle, the alarms rise on the (TIMEOUT_CYC+2)-th reference rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_clk | input | 8 | Monitored line receive clocks, one per channel |
| pll_clk | input | 8 | Monitored PLL reference clocks, one per channel |
| sel | input | 3 | Binary index of the channel that drives both alarm outputs |
| line_alarm | output | 1 | Loss alarm of the selected line clock |
| pll_alarm | output | 1 | Loss alarm of the selected PLL clock |

## Verification
Each result has a fixed latency, counted from a monitored-clock toggle made between reference edges:
- A line clear is due at the third rising edge after the toggle.
- A PLL clear is due QUAL_CYC edges after the line clear would be.
- A timeout alarm is due TIMEOUT_CYC+3 edges after the last toggle.
- After reset release the first alarm is due TIMEOUT_CYC+2 edges later.
- A change of `sel` shows up within the same cycle.

Before each stimulus, the driver queues the expected level for the exact cycle it is due. Where an off-by-one error would show, it also queues the opposite level one cycle earlier. The monitor compares each queued level in its own cycle, midway between edges.

// File: rtl/clm_pkg.sv
package clm_pkg;

  // Defaults for a 250 MHz reference: 250 ms timeout, 250 us qualification,
  // 10 us allowed gap between edges while qualifying.
  localparam int unsigned CLM_TIMEOUT_DEF = 62_500_000;
  localparam int unsigned CLM_QUAL_DEF    = 62_500;
  localparam int unsigned CLM_STALL_DEF   = 2_500;
  localparam int unsigned CLM_SYNC_DEF    = 2;

  typedef enum logic [1:0] {
    MON_OK   = 2'd0,  // clock present, alarm low
    MON_DOWN = 2'd1,  // alarm high, waiting for an edge
    MON_QUAL = 2'd2   // alarm high, qualifying recovered clock
  } mon_state_e;

endpackage

// File: rtl/clm_edge_det.sv
module clm_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic edge_seen
);

  // SYNC_STAGES synchroniser flops followed by one history flop
  logic [SYNC_STAGES:0] shift_q, shift_d;

  always_comb begin
    shift_d = {shift_q[SYNC_STAGES-1:0], mon_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign edge_seen = shift_q[SYNC_STAGES] ^ shift_q[SYNC_STAGES-1];

endmodule

// File: rtl/clm_watch.sv
module clm_watch
  import clm_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = CLM_TIMEOUT_DEF,
  parameter int unsigned QUAL_CYC    = CLM_QUAL_DEF,
  parameter int unsigned STALL_CYC   = CLM_STALL_DEF,
  parameter bit          QUALIFY     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic alarm
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] T_LAST = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] S_LAST = CW'(STALL_CYC - 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);

  mon_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic          qcnt_en;

  // cycles since last edge, saturating at the timeout point
  always_comb begin
    cnt_en = edge_seen || (cnt_q != T_LAST);
    cnt_d  = edge_seen ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    qcnt_en = 1'b0;
    qcnt_d  = qcnt_q + 1'b1;
    unique case (state_q)
      MON_OK: begin
        if (!edge_seen && cnt_q == T_LAST) state_d = MON_DOWN;
      end
      MON_DOWN: begin
        if (edge_seen) begin
          if (QUALIFY) begin
            state_d = MON_QUAL;
            qcnt_en = 1'b1;
            qcnt_d  = '0;
          end else begin
            state_d = MON_OK;
          end
        end
      end
      MON_QUAL: begin
        if (!edge_seen && cnt_q == S_LAST) state_d = MON_DOWN;
        else if (qcnt_q == Q_LAST)         state_d = MON_OK;
        else                               qcnt_en = 1'b1;
      end
      default: state_d = MON_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MON_OK;
      cnt_q   <= '0;
      qcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (qcnt_en) qcnt_q <= qcnt_d;
    end
  end

  assign alarm = (state_q != MON_OK);

  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> cnt_q == '0); // R4
  AST_RISE_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(cnt_q) == T_LAST); // R1
  AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_seen && cnt_q == T_LAST) |=> alarm); // R1

  if (QUALIFY) begin : g_qual_chk
    AST_QUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MON_DOWN && edge_seen) |=> alarm); // R3
    AST_STALL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MON_QUAL && !edge_seen && cnt_q == S_LAST) |=> (alarm && state_q == MON_DOWN)); // R5
  end else begin : g_fast_chk
    AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm && edge_seen) |=> !alarm); // R2
  end

endmodule

// File: rtl/clk_loss_mon.sv
module clk_loss_mon
  import clm_pkg::*;
#(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned TIMEOUT_CYC = CLM_TIMEOUT_DEF,
  parameter int unsigned QUAL_CYC    = CLM_QUAL_DEF,
  parameter int unsigned STALL_CYC   = CLM_STALL_DEF,
  parameter int unsigned SYNC_STAGES = CLM_SYNC_DEF,
  localparam int unsigned SEL_W      = $clog2(NUM_CH)
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] line_clk,
  input  logic [NUM_CH-1:0] pll_clk,
  input  logic [SEL_W-1:0]  sel,
  output logic              line_alarm,
  output logic              pll_alarm
);

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end

  assign rst_s_n = rsync_q[1];

  logic [NUM_CH-1:0] line_edge, pll_edge;
  logic [NUM_CH-1:0] line_alm_vec, pll_alm_vec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    clm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_line_edge (
      .clk(ref_clk), .rst_n(rst_s_n), .mon_clk(line_clk[ch]), .edge_seen(line_edge[ch])
    );
    clm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_pll_edge (
      .clk(ref_clk), .rst_n(rst_s_n), .mon_clk(pll_clk[ch]), .edge_seen(pll_edge[ch])
    );
    clm_watch #(
      .TIMEOUT_CYC(TIMEOUT_CYC), .QUAL_CYC(QUAL_CYC),
      .STALL_CYC(STALL_CYC), .QUALIFY(1'b0)
    ) u_line_watch (
      .clk(ref_clk), .rst_n(rst_s_n), .edge_seen(line_edge[ch]), .alarm(line_alm_vec[ch])
    );
    clm_watch #(
      .TIMEOUT_CYC(TIMEOUT_CYC), .QUAL_CYC(QUAL_CYC),
      .STALL_CYC(STALL_CYC), .QUALIFY(1'b1)
    ) u_pll_watch (
      .clk(ref_clk), .rst_n(rst_s_n), .edge_seen(pll_edge[ch]), .alarm(pll_alm_vec[ch])
    );
  end

  assign line_alarm = line_alm_vec[sel];
  assign pll_alarm  = pll_alm_vec[sel];

  AST_RESET_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !rst_s_n |-> (!line_alarm && !pll_alarm)); // R7
  AST_ONE_CYCLE_RISE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(rst_s_n) |-> (!line_alarm && !pll_alarm)); // R7

endmodule

// File: tb/tb_clk_loss_mon.sv
module tb_clk_loss_mon;

  localparam int T  = 40;
  localparam int QL = 12;
  localparam int ST = 6;

  logic       ref_clk;
  logic       rst_n;
  logic [7:0] line_clk, pll_clk;
  logic [7:0] line_run, pll_run;
  logic [2:0] sel;
  logic       line_alarm, pll_alarm;

  int cyc;
  int tests;
  int fails;

  typedef struct {
    int    due;
    bit    is_pll;
    bit    exp;
    string req;
  } exp_t;

  exp_t exp_q[$];

  clk_loss_mon #(
    .NUM_CH(8), .TIMEOUT_CYC(T), .QUAL_CYC(QL), .STALL_CYC(ST), .SYNC_STAGES(2)
  ) dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .line_clk(line_clk), .pll_clk(pll_clk),
    .sel(sel), .line_alarm(line_alarm), .pll_alarm(pll_alarm)
  );

  initial begin
    ref_clk = 1'b0;
    forever #2 ref_clk = ~ref_clk;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge ref_clk);
      cyc = cyc + 1;
    end
  end

  // toggler: every bit set in a run mask flips its clock once per reference cycle
  initial begin
    line_clk = '0;
    pll_clk  = '0;
    forever begin
      @(negedge ref_clk);
      #1;
      line_clk = line_clk ^ line_run;
      pll_clk  = pll_clk ^ pll_run;
    end
  end

  task automatic push(input int due, input bit is_pll, input bit exp, input string req);
    exp_t it;
    int   i;
    it.due = due; it.is_pll = is_pll; it.exp = exp; it.req = req;
    i = 0;
    while (i < exp_q.size() && exp_q[i].due <= due) i++;
    exp_q.insert(i, it);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge ref_clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // monitor: compares scoreboard entries midway between edges
  initial begin
    exp_t it;
    bit   act;
    tests = 0;
    fails = 0;
    forever begin
      @(negedge ref_clk);
      #1.5;
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        it  = exp_q.pop_front();
        act = it.is_pll ? pll_alarm : line_alarm;
        tests++;
        if (it.due < cyc) begin
          fails++;
          $display("FAIL %s: check for cycle %0d missed at cycle %0d, expected %0b", it.req, it.due, cyc, it.exp);
        end else if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: %s alarm at cycle %0d = %0b, expected %0b",
                   it.req, it.is_pll ? "pll" : "line", cyc, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge ref_clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run reached cycle %0d, expected to end before %0d", cyc, 20000);
    finish_run();
  end

  initial begin
    int a, c, d, s, l;
    rst_n    = 1'b0;
    sel      = 3'd0;
    line_run = '0;
    pll_run  = '0;
    wait_cyc(3);

    // R7 reset state and release; R1 alarm from idle clocks
    a = cyc;
    push(a + 1, 0, 0, "R7");
    push(a + 1, 1, 0, "R7");
    push(a + 1 + T, 0, 0, "R7");
    push(a + 1 + T, 1, 0, "R7");
    push(a + 2 + T, 0, 1, "R1");
    push(a + 2 + T, 1, 1, "R1");
    rst_n = 1'b1;
    wait_until(a + T + 6);

    // R2 line clears at once, R3 PLL clears after qualification
    c = cyc;
    push(c + 2, 0, 1, "R2");
    push(c + 3, 0, 0, "R2");
    push(c + 3, 1, 1, "R3");
    push(c + 2 + QL, 1, 1, "R3");
    push(c + 3 + QL, 1, 0, "R3");
    line_run[0] = 1'b1;
    pll_run[0]  = 1'b1;
    wait_cyc(20);
    line_run[0] = 1'b0;
    pll_run[0]  = 1'b0;
    l = c + 19;
    push(l + 2 + T, 0, 0, "R1");
    push(l + 3 + T, 0, 1, "R1");
    push(l + 2 + T, 1, 0, "R1");
    push(l + 3 + T, 1, 1, "R1");
    wait_until(l + T + 6);

    // R4 sparse edges keep restarting the count
    c = cyc;
    push(c + 3, 0, 0, "R4");
    push(c + 3 + T, 0, 0, "R4");
    push(c + 62 + T, 0, 0, "R4");
    push(c + 63 + T, 0, 1, "R4");
    line_run[0] = 1'b1; wait_cyc(1); line_run[0] = 1'b0;
    wait_until(c + 30);
    line_run[0] = 1'b1; wait_cyc(1); line_run[0] = 1'b0;
    wait_until(c + 60);
    line_run[0] = 1'b1; wait_cyc(1); line_run[0] = 1'b0;
    wait_until(c + 63 + T + 3);

    // R5 stall during qualification, then a fresh full window
    c = cyc;
    push(c + 3 + QL, 1, 1, "R5");
    push(c + 4 + QL, 1, 1, "R5");
    pll_run[0] = 1'b1;
    wait_cyc(3);
    pll_run[0] = 1'b0;
    wait_until(c + 20);
    d = cyc;
    push(d + 2 + QL, 1, 1, "R5");
    push(d + 3 + QL, 1, 0, "R5");
    pll_run[0] = 1'b1;
    wait_cyc(20);
    pll_run[0] = 1'b0;
    wait_until(d + 25);

    // R6 channel select
    c = cyc;
    line_run[5] = 1'b1;
    pll_run[5]  = 1'b1;
    wait_until(c + QL + 5);
    s = cyc;
    sel = 3'd5;
    push(s + 1, 0, 0, "R6");
    push(s + 1, 1, 0, "R6");
    wait_until(s + 4);
    sel = 3'd7;
    push(s + 5, 0, 1, "R6");
    push(s + 5, 1, 1, "R6");
    wait_until(s + 8);
    line_run[5] = 1'b0;
    pll_run[5]  = 1'b0;

    while (exp_q.size() > 0) @(negedge ref_clk);
    wait_cyc(2);
    finish_run();
  end

endmodule